// File: doc/BRIEF.md
# Multi-Width FIFO Host Data Port

This block connects a 32-bit memory-mapped host bus to the transmit and receive byte FIFOs of one serial channel. A single bus access moves from one to four bytes. The byte enables of the access set the count and the lanes. A write to the data window pushes the enabled bytes into the transmit FIFO. A read of the same window pops the receive FIFO into the enabled lanes. In both directions the lowest enabled lane carries the oldest byte. Each FIFO pointer advances by the number of bytes actually moved.

The receive FIFO stores a 3-bit error tag (parity, framing, break) with every byte. A second read window returns each received byte with its tag byte beside it. This keeps a byte and its line status together in one access. That window accepts only aligned 16-bit reads (one entry) or 32-bit reads (two entries). Any other width is refused, and the refusal is signalled by an error pulse.

The channel owns a 512-byte window inside a 1 KB region, selected by address bit 9. In channel zero, a block of device-wide registers occupies offsets 0x080 to 0x093. Accesses to that block never reach the FIFOs. The serial side pops transmit bytes one at a time and pushes received bytes one at a time.

Top module: `fifo_host_port`

## Requirements
- R1: A request whose address bit 9 differs from the CHANNEL parameter is ignored: no read response, no error, and no FIFO change.
- R2: With CHANNEL 0, requests at byte offsets 0x080 to 0x093 touch neither FIFO and produce no read response. Offset 0x094 already belongs to the data window.
- R3: A write at offsets 0x000 to 0x0FF outside the block of R2 pushes one byte per set enable bit. The lowest enabled lane is pushed first. tx_count_o rises by that number at the clock edge that takes the request.
- R4: A read of the data window returns the oldest receive bytes in the enabled lanes, lowest lane first, with zero in the disabled lanes. rdata_o and rvalid_o are registered one clock after the request. rx_count_o falls by the bytes moved at that same edge.
- R5: When a read asks for more bytes than the receive FIFO holds, the lanes beyond the held count return zero and only the held bytes are popped.
- R6: When a write offers more bytes than the transmit FIFO has free, the excess bytes are dropped and tx_ovf_o is set. tx_ovf_o stays set until ovf_clr_i is high for a clock with no new overflow.
- R7: At offsets 0x100 to 0x1FF a read with enables 0011 pops one entry into bits 15:0. Enables 1100 pop one entry into bits 31:16. Enables 1111 pop two entries, the older one in bits 15:0. Each 16-bit half holds the data byte low and the tag byte high, with tag bit 0 parity, bit 1 framing, bit 2 break and the upper five bits zero. A half with no entry reads zero.
- R8: A read of the paired window with any other enable pattern pops nothing. It returns zero data with rvalid_o and a one-clock err_o pulse. Writes to the paired window are ignored.
- R9: tx_data_o shows the oldest transmit byte, and tx_pop_i removes it. A pop on an empty FIFO has no effect. rx_push_i stores rx_data_i together with rx_err_i (bit 0 parity, bit 1 framing, bit 2 break). A push into a full receive FIFO is dropped.
- R10: After reset both counts are zero and tx_ovf_o, rvalid_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address, byte-address bits 9:2 |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read response, one clock after the request |
| err_o | output | 1 | Refused paired-window read |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| ovf_clr_i | input | 1 | Clears tx_ovf_o |
| tx_pop_i | input | 1 | Serial side takes one transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_count_o | output | CW | Transmit FIFO fill level |
| rx_push_i | input | 1 | Serial side stores one received byte |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 3 | Error tag of the received byte |
| rx_count_o | output | CW | Receive FIFO fill level |

## Verification
The bench builds the block with DEPTH 8 and CHANNEL 0. The shallow FIFOs let a few four-byte writes reach full and the overflow path. Random reads therefore often cross the empty boundary and exercise partial returns. CHANNEL 0 puts the device-register hole inside the data window, so its edges at 0x07C, 0x080, 0x090 and 0x094 can be tested. Setting address bit 9 covers the foreign-channel case.

// File: rtl/fhp_pkg.sv
package fhp_pkg;
  typedef enum logic [1:0] {WIN_NONE, WIN_DATA, WIN_PAIR} win_e;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;
  typedef struct packed {
    rx_tag_t    tag;
    logic [7:0] data;
  } rx_ent_t;
endpackage

// File: rtl/fhp_win_decode.sv
module fhp_win_decode
  import fhp_pkg::*;
#(
  parameter int unsigned CHANNEL = 0
) (
  input  logic       req_i,
  input  logic [9:2] addr_i,
  output win_e       win_o
);
  logic own, cfg;
  assign own = (addr_i[9] == 1'(CHANNEL));
  // device register hole, channel zero only
  assign cfg = (CHANNEL == 0) && (addr_i[8:2] >= 7'h20) && (addr_i[8:2] <= 7'h24);

  always_comb begin
    win_o = WIN_NONE;
    if (req_i && own) begin
      if (addr_i[8])  win_o = WIN_PAIR;
      else if (!cfg)  win_o = WIN_DATA;
    end
  end
endmodule

// File: rtl/fhp_lane_map.sv
module fhp_lane_map (
  input  logic [3:0]      be_i,
  output logic [3:0][1:0] slot_o,
  output logic [2:0]      nbytes_o
);
  logic [2:0] acc;
  always_comb begin
    acc = '0;
    for (int l = 0; l < 4; l++) begin
      slot_o[l] = acc[1:0];
      acc = acc + 3'(be_i[l]);
    end
    nbytes_o = acc;
  end
endmodule

// File: rtl/fhp_fifo.sv
module fhp_fifo #(
  parameter int unsigned W        = 8,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned WR_LANES = 4,
  parameter int unsigned RD_LANES = 1,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   push_req_i,
  input  logic [WR_LANES-1:0][W-1:0]   push_data_i,
  input  logic [2:0]                   pop_req_i,
  output logic [RD_LANES-1:0][W-1:0]   head_o,
  output logic [CW-1:0]                cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wr_q, rd_q, cnt, free, push_ext, pop_ext, push_g, pop_g;

  assign cnt      = wr_q - rd_q;
  assign free     = CW'(DEPTH) - cnt;
  assign push_ext = CW'(push_req_i);
  assign pop_ext  = CW'(pop_req_i);
  // grants clipped to space / content held at cycle start
  assign push_g   = (push_ext > free) ? free : push_ext;
  assign pop_g    = (pop_ext > cnt) ? cnt : pop_ext;
  assign cnt_o    = cnt;

  always_comb begin
    for (int k = 0; k < RD_LANES; k++)
      head_o[k] = (CW'(k) < cnt) ? mem[AW'(rd_q + CW'(k))] : '0;
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < WR_LANES; k++)
      if (CW'(k) < push_g) mem[AW'(wr_q + CW'(k))] <= push_data_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_q + push_g;
      rd_q <= rd_q + pop_g;
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
  a_r5_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && push_req_i == '0) |=> cnt_o == '0);
endmodule

// File: rtl/fifo_host_port.sv
module fifo_host_port
  import fhp_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned CHANNEL = 0,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [9:2]    addr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          rvalid_o,
  output logic          err_o,
  output logic          tx_ovf_o,
  input  logic          ovf_clr_i,
  input  logic          tx_pop_i,
  output logic [7:0]    tx_data_o,
  output logic [CW-1:0] tx_count_o,
  input  logic          rx_push_i,
  input  logic [7:0]    rx_data_i,
  input  logic [2:0]    rx_err_i,
  output logic [CW-1:0] rx_count_o
);
  localparam int unsigned EW = $bits(rx_ent_t);

  win_e            win;
  logic [3:0][1:0] slot;
  logic [2:0]      nbytes, pair_n, rx_pop_req;
  logic            tx_wr, rx_rd, pair_rd, pair_bad, ovf_set;
  logic [3:0][7:0] tx_in;
  logic [0:0][7:0] tx_head;
  logic [0:0][EW-1:0] rx_in;
  logic [3:0][EW-1:0] rx_head;
  logic [31:0]     rd_next;

  fhp_win_decode #(.CHANNEL(CHANNEL)) u_dec (
    .req_i(req_i), .addr_i(addr_i), .win_o(win));

  fhp_lane_map u_map (.be_i(be_i), .slot_o(slot), .nbytes_o(nbytes));

  assign tx_wr   = (win == WIN_DATA) && we_i;
  assign rx_rd   = (win == WIN_DATA) && !we_i;
  assign pair_rd = (win == WIN_PAIR) && !we_i;

  always_comb begin
    unique case (be_i)
      4'b0011, 4'b1100: pair_n = 3'd1;
      4'b1111:          pair_n = 3'd2;
      default:          pair_n = 3'd0;
    endcase
  end
  assign pair_bad   = pair_rd && (pair_n == 3'd0);
  assign rx_pop_req = rx_rd ? nbytes : (pair_rd ? pair_n : 3'd0);

  always_comb begin
    tx_in = '0;
    for (int l = 0; l < 4; l++)
      if (be_i[l]) tx_in[slot[l]] = wdata_i[8*l +: 8];
  end

  fhp_fifo #(.W(8), .DEPTH(DEPTH), .WR_LANES(4), .RD_LANES(1)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_req_i(tx_wr ? nbytes : 3'd0), .push_data_i(tx_in),
    .pop_req_i({2'b00, tx_pop_i}), .head_o(tx_head), .cnt_o(tx_count_o));

  assign rx_in[0] = {rx_err_i, rx_data_i};

  fhp_fifo #(.W(EW), .DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(4)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_req_i({2'b00, rx_push_i}), .push_data_i(rx_in),
    .pop_req_i(rx_pop_req), .head_o(rx_head), .cnt_o(rx_count_o));

  assign tx_data_o = tx_head[0];
  assign ovf_set   = tx_wr && (CW'(nbytes) > (CW'(DEPTH) - tx_count_o));

  function automatic logic [15:0] pair_half(input logic [EW-1:0] raw);
    rx_ent_t e;
    e = rx_ent_t'(raw);
    return {5'b0, e.tag, e.data};
  endfunction

  // heads beyond the fill level read zero, so short reads need no extra masking
  always_comb begin
    rd_next = '0;
    if (rx_rd) begin
      for (int l = 0; l < 4; l++)
        if (be_i[l]) rd_next[8*l +: 8] = rx_head[slot[l]][7:0];
    end else if (pair_rd) begin
      unique case (be_i)
        4'b0011: rd_next[15:0]  = pair_half(rx_head[0]);
        4'b1100: rd_next[31:16] = pair_half(rx_head[0]);
        4'b1111: rd_next        = {pair_half(rx_head[1]), pair_half(rx_head[0])};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      tx_ovf_o <= 1'b0;
    end else begin
      rdata_o  <= rd_next;
      rvalid_o <= rx_rd || pair_rd;
      err_o    <= pair_bad;
      if (ovf_set)        tx_ovf_o <= 1'b1;
      else if (ovf_clr_i) tx_ovf_o <= 1'b0;
    end
  end

  a_r1_foreign_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[9] != 1'(CHANNEL)) |=> (!rvalid_o && !err_o));
  a_r2_cfg_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && CHANNEL == 0 && !addr_i[9] && addr_i[8:2] >= 7'h20 && addr_i[8:2] <= 7'h24)
      |=> (!rvalid_o && !err_o));
  a_r3_full_word_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[9] == 1'(CHANNEL) && addr_i[8:2] < 7'h20 && be_i == 4'hF
     && !tx_pop_i && tx_count_o <= CW'(DEPTH - 4))
      |=> tx_count_o == $past(tx_count_o) + CW'(4));
  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_o && !ovf_clr_i) |=> tx_ovf_o);
  a_r8_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rvalid_o && rdata_o == '0));
endmodule

// File: tb/tb_fifo_host_port.sv
`timescale 1ns/1ps
module tb_fifo_host_port;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, ovf_clr_i = 0, tx_pop_i = 0, rx_push_i = 0;
  logic [9:2] addr_i = '0;
  logic [3:0] be_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic rvalid_o, err_o, tx_ovf_o;
  logic [7:0] tx_data_o, rx_data_i = '0;
  logic [2:0] rx_err_i = '0;
  logic [CW-1:0] tx_count_o, rx_count_o;

  always #4 clk = ~clk;

  fifo_host_port #(.DEPTH(DEPTH), .CHANNEL(0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .err_o(err_o), .tx_ovf_o(tx_ovf_o), .ovf_clr_i(ovf_clr_i), .tx_pop_i(tx_pop_i),
    .tx_data_o(tx_data_o), .tx_count_o(tx_count_o), .rx_push_i(rx_push_i),
    .rx_data_i(rx_data_i), .rx_err_i(rx_err_i), .rx_count_o(rx_count_o));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  txm[$];
  logic [10:0] rxm[$];
  bit ovfm = 0;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus(bit we, logic [9:0] ba, logic [3:0] be, logic [31:0] wd, string req);
    logic [31:0] exp_rd = '0;
    logic [10:0] e;
    bit exp_v = 0, exp_e = 0;
    bit own = (ba[9] == 1'b0);
    bit cfg = (ba[8:2] >= 7'h20) && (ba[8:2] <= 7'h24);
    if (own && !ba[8] && !cfg) begin
      if (we) begin
        for (int l = 0; l < 4; l++)
          if (be[l]) begin
            if (txm.size() < DEPTH) txm.push_back(wd[8*l +: 8]);
            else ovfm = 1;
          end
      end else begin
        exp_v = 1;
        for (int l = 0; l < 4; l++)
          if (be[l] && rxm.size() > 0) begin
            e = rxm.pop_front();
            exp_rd[8*l +: 8] = e[7:0];
          end
      end
    end else if (own && ba[8] && !we) begin
      exp_v = 1;
      case (be)
        4'b0011: if (rxm.size() > 0) begin e = rxm.pop_front(); exp_rd[15:0] = {5'b0, e}; end
        4'b1100: if (rxm.size() > 0) begin e = rxm.pop_front(); exp_rd[31:16] = {5'b0, e}; end
        4'b1111: begin
          if (rxm.size() > 0) begin e = rxm.pop_front(); exp_rd[15:0] = {5'b0, e}; end
          if (rxm.size() > 0) begin e = rxm.pop_front(); exp_rd[31:16] = {5'b0, e}; end
        end
        default: exp_e = 1;
      endcase
    end
    @(negedge clk);
    req_i = 1; we_i = we; addr_i = ba[9:2]; be_i = be; wdata_i = wd;
    @(negedge clk);
    req_i = 0;
    chk(req, "rvalid", rvalid_o, exp_v);
    chk(req, "err", err_o, exp_e);
    if (exp_v) chk(req, "rdata", rdata_o, exp_rd);
    chk(req, "tx_count", tx_count_o, txm.size());
    chk(req, "rx_count", rx_count_o, rxm.size());
    chk(req, "tx_ovf", tx_ovf_o, ovfm);
  endtask

  task automatic rx_push(logic [7:0] d, logic [2:0] er);
    @(negedge clk);
    rx_push_i = 1; rx_data_i = d; rx_err_i = er;
    @(negedge clk);
    rx_push_i = 0;
    if (rxm.size() < DEPTH) rxm.push_back({er, d});
    chk("R9", "rx_count after push", rx_count_o, rxm.size());
  endtask

  task automatic tx_pop();
    @(negedge clk);
    if (txm.size() > 0) chk("R9", "tx_data head", tx_data_o, txm[0]);
    tx_pop_i = 1;
    @(negedge clk);
    tx_pop_i = 0;
    if (txm.size() > 0) void'(txm.pop_front());
    chk("R9", "tx_count after pop", tx_count_o, txm.size());
  endtask

  task automatic ovf_clear();
    @(negedge clk);
    ovf_clr_i = 1;
    @(negedge clk);
    ovf_clr_i = 0;
    ovfm = 0;
    chk("R6", "tx_ovf after clear", tx_ovf_o, 0);
  endtask

  function automatic logic [9:0] data_addr(int unsigned r);
    logic [6:0] w = 7'(r % 57);  // 32 words below the hole, 25 above
    if (w >= 7'h20) w = w + 7'd5;
    return {1'b0, 1'b0, w, 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "tx_count", tx_count_o, 0);
    chk("R10", "rx_count", rx_count_o, 0);
    chk("R10", "rvalid", rvalid_o, 0);
    chk("R10", "err", err_o, 0);
    chk("R10", "tx_ovf", tx_ovf_o, 0);
    rst_ni = 1;
    // R3: lane order on full and sparse enables
    bus(1, 10'h000, 4'b1111, 32'h4433_2211, "R3");
    bus(1, 10'h07C, 4'b0110, 32'hAA66_55BB, "R3");
    for (int i = 0; i < 6; i++) tx_pop();
    tx_pop();  // R9 pop on empty
    // R2: device register hole and its edges
    bus(1, 10'h080, 4'b1111, 32'h1, "R2");
    bus(1, 10'h090, 4'b1111, 32'h2, "R2");
    bus(0, 10'h084, 4'b1111, 32'h0, "R2");
    bus(1, 10'h094, 4'b0001, 32'h77, "R2");
    tx_pop();
    // R1: other channel
    bus(1, 10'h200, 4'b1111, 32'h5, "R1");
    bus(0, 10'h300, 4'b1111, 32'h0, "R1");
    // R6: overflow and sticky clear
    bus(1, 10'h000, 4'b1111, 32'h0403_0201, "R6");
    bus(1, 10'h004, 4'b0111, 32'h0007_0605, "R6");
    bus(1, 10'h008, 4'b1111, 32'h0B0A_0908, "R6");
    bus(1, 10'h000, 4'b0001, 32'h0C, "R6");
    ovf_clear();
    while (txm.size() > 0) tx_pop();
    // R5: read beyond content
    rx_push(8'h31, 3'b000);
    rx_push(8'h32, 3'b001);
    bus(0, 10'h000, 4'b1111, 32'h0, "R5");
    bus(0, 10'h010, 4'b0011, 32'h0, "R5");
    // R4: sparse read lanes
    for (int i = 0; i < 4; i++) rx_push(8'h40 + 8'(i), 3'(i));
    bus(0, 10'h020, 4'b1010, 32'h0, "R4");
    bus(0, 10'h0FC, 4'b0100, 32'h0, "R4");
    // R7: paired window with tags
    rx_push(8'h51, 3'b100);
    rx_push(8'h52, 3'b010);
    bus(0, 10'h100, 4'b1111, 32'h0, "R7");
    bus(0, 10'h1FC, 4'b1100, 32'h0, "R7");
    bus(0, 10'h104, 4'b0011, 32'h0, "R7");
    // R8: refused paired widths and paired writes
    rx_push(8'h61, 3'b111);
    bus(0, 10'h100, 4'b0001, 32'h0, "R8");
    bus(0, 10'h100, 4'b0111, 32'h0, "R8");
    bus(0, 10'h100, 4'b0110, 32'h0, "R8");
    bus(1, 10'h100, 4'b1111, 32'hDEAD, "R8");
    bus(0, 10'h100, 4'b0011, 32'h0, "R8");
    // R9: receive push into full FIFO dropped
    for (int i = 0; i < DEPTH + 2; i++) rx_push(8'h70 + 8'(i), 3'(i));
    bus(0, 10'h000, 4'b1111, 32'h0, "R9");
    // random mix
    for (int it = 0; it < 600; it++) begin
      int unsigned op = $urandom % 8;
      logic [3:0] be = 4'($urandom);
      case (op)
        0, 1: rx_push(8'($urandom), 3'($urandom));
        2:    tx_pop();
        3:    bus(1, data_addr($urandom), be, $urandom, "R3");
        4:    bus(0, data_addr($urandom), be, 32'h0, "R4");
        5:    bus(0, {2'b01, 6'($urandom), 2'b00}, be, 32'h0, "R7");
        6:    bus($urandom % 2 == 1, {3'b000, 3'b100, 2'($urandom % 5 == 4 ? 0 : $urandom % 5), 2'b00}, be, $urandom, "R2");
        default: begin
          if (ovfm) ovf_clear();
          else bus($urandom % 2 == 1, {1'b1, 7'($urandom), 2'b00}, be, $urandom, "R1");
        end
      endcase
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule